// File: doc/BRIEF.md
# Trigger Latency Pipeline with Windowed Readout

This block holds digitized detector samples from many channels in a fixed digital delay while a first-level trigger decision is pending. During each bunch crossing the channel samples arrive one after another on a single 16-bit input, in ascending channel order. The block writes each sample into a circular history that is indexed by crossing and channel. After the last channel of a crossing, the crossing pointer advances and wraps modulo the history depth.

When an accept pulse arrives, the block finds the triggered crossing, which lies a programmable number of crossings behind the crossing currently being written. For every channel it reads that crossing and the following samples that make up the window. The samples go into a first-word-fall-through readout queue. Each event carries a trigger tag so that downstream energy and timing filters can assemble it. If the queue cannot take a whole event, or if the previous event is still being extracted, the block drops the event completely and raises a sticky overflow flag. The latency is a configuration input, so the delay can be lengthened without any change to the hardware.

Top module: `l1_latency_pipe`

## Requirements
- R1: After synchronous reset the readout queue is empty (`out_valid`=0), `fifo_full`=0, `overflow`=0, the next trigger tag is 0, and writing starts at channel 0 of crossing 0.
- R2: Each cycle with `in_valid`=1 stores `in_sample` for the current channel. The channel count runs from 0 to NCH-1, and after channel NCH-1 the crossing index advances by one.
- R3: An accepted trigger on a clock edge at which X crossings are complete extracts, for every channel, the samples of crossings X-L through X-L+WIN-1, where L is the value of `lat_cfg` on that edge. L must lie between WIN and DEPTH-16, which is 5 to 112 by default.
- R4: The entries of an event leave in ascending channel order. Within a channel they leave oldest first, with `out_sidx` running 0..WIN-1 and `out_ch` giving the channel.
- R5: Every accept pulse, kept or dropped, advances an 8-bit trigger counter. A kept event carries in `out_tag` the counter value from before that advance, so the first event after reset carries tag 0.
- R6: For an accept on edge k, entry i of the event (i = channel*WIN + sample index) enters the queue on edge k+2+i.
- R7: The queue is first-word-fall-through. `out_valid` is high while it holds entries, and `rd_en` with `out_valid` removes the head on the next edge. A push and a pop on the same edge both take effect.
- R8: `fifo_full` is high exactly when the queue holds FDEPTH entries.
- R9: An accept is dropped whole when FDEPTH minus the stored entries minus any entry in flight is less than NCH*WIN. A dropped event adds no entry, and it sets `overflow`, which stays set until reset.
- R10: An accept that arrives while an earlier event is still being read from the history is dropped and sets `overflow`.
- R11: A changed `lat_cfg` applies to the next accept without any other action.
- R12: The history wraps modulo DEPTH crossings, and extraction stays correct after the write pointer has wrapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lat_cfg | input | $clog2(DEPTH) | Trigger latency in crossings |
| in_valid | input | 1 | Sample present for the current channel |
| in_sample | input | 16 | Digitized sample |
| l1a | input | 1 | Trigger accept pulse |
| rd_en | input | 1 | Pop the readout queue head |
| out_valid | output | 1 | Queue head is valid |
| out_tag | output | 8 | Trigger tag of the head entry |
| out_ch | output | $clog2(NCH) | Channel of the head entry |
| out_sidx | output | $clog2(WIN) | Sample position within the window |
| out_sample | output | 16 | Sample value of the head entry |
| fifo_full | output | 1 | Queue holds FDEPTH entries |
| overflow | output | 1 | Sticky event-drop flag |

## Verification
Two things can fall on the same edge here. The extraction engine can push a window entry into the readout queue on the same edge that the consumer pops the head, and an accept can land on the same edge as the write of a crossing's last channel. The bench drains the queue with a `rd_en` pattern that is high two cycles in three while events are still streaming in. It also sends the input with periodic gaps, so that accepts fall at every channel phase. The behavioural model applies the pop, the push, the accept and the write for each edge in their required order, and it compares the queue head, the full flag and the overflow flag after every edge.

// File: rtl/l1lp_pkg.sv
package l1lp_pkg;

    localparam int SAMPLE_W = 16;
    localparam int TAG_W    = 8;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [TAG_W-1:0]    tag_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // index width that never collapses to zero bits
    function automatic int idx_w(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/l1lp_ring.sv
module l1lp_ring
    import l1lp_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int DEPTH = 128
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  sample_t                   wr_data,
    input  logic [idx_w(DEPTH)-1:0]   rd_xing,
    input  logic [idx_w(NCH)-1:0]     rd_ch,
    output logic [idx_w(DEPTH)-1:0]   wr_xing,
    output sample_t                   rd_data
);

    localparam int AW     = idx_w(DEPTH);
    localparam int CHW    = idx_w(NCH);
    localparam int WORDS  = DEPTH * NCH;
    localparam int ADDR_W = idx_w(WORDS);

    logic [CHW-1:0]    wch;
    logic [AW-1:0]     wx;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    sample_t           mem [WORDS];

    assign waddr   = ADDR_W'(wx) * ADDR_W'(NCH) + ADDR_W'(wch);
    assign raddr   = ADDR_W'(rd_xing) * ADDR_W'(NCH) + ADDR_W'(rd_ch);
    assign wr_xing = wx;

    always_ff @(posedge clk) begin
        if (rst) begin
            wch <= '0;
            wx  <= '0;
        end else if (wr_en) begin
            if (wch == CHW'(NCH - 1)) begin
                wch <= '0;
                wx  <= wx + AW'(1);
            end else begin
                wch <= wch + CHW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[waddr] <= wr_data;
        rd_data <= mem[raddr];
    end

endmodule

// File: rtl/l1lp_window_seq.sv
module l1lp_window_seq
    import l1lp_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int DEPTH  = 128,
    parameter int WIN    = 5,
    parameter int FDEPTH = 64
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        l1a,
    input  logic [idx_w(DEPTH)-1:0]     lat_cfg,
    input  logic [idx_w(DEPTH)-1:0]     wr_xing,
    input  logic [$clog2(FDEPTH+1)-1:0] fifo_count,
    output logic [idx_w(DEPTH)-1:0]     rd_xing,
    output logic [idx_w(NCH)-1:0]       rd_ch,
    output logic                        push_v,
    output tag_t                        push_tag,
    output logic [idx_w(NCH)-1:0]       push_ch,
    output logic [idx_w(WIN)-1:0]       push_sidx,
    output logic                        busy,
    output logic                        overflow
);

    localparam int AW  = idx_w(DEPTH);
    localparam int CHW = idx_w(NCH);
    localparam int SW  = idx_w(WIN);
    localparam int EVT = NCH * WIN;

    seq_state_e     st;
    logic [AW-1:0]  base;
    logic [CHW-1:0] c;
    logic [SW-1:0]  s;
    tag_t           tag_cnt;
    tag_t           ev_tag;
    logic           room_ok;
    logic           last_item;
    logic           sidx_end;

    assign room_ok   = (int'(fifo_count) + int'(push_v) + EVT) <= FDEPTH;
    assign sidx_end  = (s == SW'(WIN - 1));
    assign last_item = sidx_end && (c == CHW'(NCH - 1));
    assign rd_xing   = base + AW'(s);
    assign rd_ch     = c;
    assign busy      = (st == SEQ_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SEQ_IDLE;
            base      <= '0;
            c         <= '0;
            s         <= '0;
            tag_cnt   <= '0;
            ev_tag    <= '0;
            push_v    <= 1'b0;
            push_tag  <= '0;
            push_ch   <= '0;
            push_sidx <= '0;
            overflow  <= 1'b0;
        end else begin
            push_v <= busy;
            if (busy) begin
                push_ch   <= c;
                push_sidx <= s;
                push_tag  <= ev_tag;
                if (sidx_end) begin
                    s <= '0;
                    c <= c + CHW'(1);
                end else begin
                    s <= s + SW'(1);
                end
                if (last_item) st <= SEQ_IDLE;
            end
            if (l1a) begin
                tag_cnt <= tag_cnt + TAG_W'(1);
                if (!busy && room_ok) begin
                    st     <= SEQ_RUN;
                    base   <= wr_xing - lat_cfg;
                    c      <= '0;
                    s      <= '0;
                    ev_tag <= tag_cnt;
                end else begin
                    overflow <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/l1lp_readout_fifo.sv
module l1lp_readout_fifo
    import l1lp_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int FDEPTH = 64
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        push,
    input  logic [WIDTH-1:0]            push_data,
    input  logic                        pop_req,
    output logic                        out_valid,
    output logic [WIDTH-1:0]            out_data,
    output logic                        full,
    output logic [$clog2(FDEPTH+1)-1:0] count
);

    localparam int PW = idx_w(FDEPTH);
    localparam int CW = $clog2(FDEPTH + 1);

    logic [WIDTH-1:0] mem [FDEPTH];
    logic [PW-1:0]    wp;
    logic [PW-1:0]    rp;
    logic             pop;

    assign out_valid = (count != '0);
    assign full      = (count == CW'(FDEPTH));
    assign pop       = pop_req && out_valid;
    assign out_data  = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= (wp == PW'(FDEPTH - 1)) ? '0 : wp + PW'(1);
            if (pop)  rp <= (rp == PW'(FDEPTH - 1)) ? '0 : rp + PW'(1);
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= push_data;
    end

endmodule

// File: rtl/l1_latency_pipe.sv
module l1_latency_pipe
    import l1lp_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int DEPTH  = 128,
    parameter int WIN    = 5,
    parameter int FDEPTH = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [idx_w(DEPTH)-1:0] lat_cfg,
    input  logic                    in_valid,
    input  logic [15:0]             in_sample,
    input  logic                    l1a,
    input  logic                    rd_en,
    output logic                    out_valid,
    output logic [7:0]              out_tag,
    output logic [idx_w(NCH)-1:0]   out_ch,
    output logic [idx_w(WIN)-1:0]   out_sidx,
    output logic [15:0]             out_sample,
    output logic                    fifo_full,
    output logic                    overflow
);

    localparam int AW  = idx_w(DEPTH);
    localparam int CHW = idx_w(NCH);
    localparam int SW  = idx_w(WIN);
    localparam int CW  = $clog2(FDEPTH + 1);

    typedef struct packed {
        tag_t           tag;
        logic [CHW-1:0] ch;
        logic [SW-1:0]  sidx;
        sample_t        smp;
    } entry_t;

    logic [AW-1:0]  wr_xing;
    logic [AW-1:0]  rd_xing;
    logic [CHW-1:0] rd_ch;
    sample_t        rd_data;
    logic           push_v;
    tag_t           push_tag;
    logic [CHW-1:0] push_ch;
    logic [SW-1:0]  push_sidx;
    logic           busy;
    logic [CW-1:0]  fifo_count;
    entry_t         push_e;
    entry_t         head_e;

    l1lp_ring #(.NCH(NCH), .DEPTH(DEPTH)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (in_valid),
        .wr_data (in_sample),
        .rd_xing (rd_xing),
        .rd_ch   (rd_ch),
        .wr_xing (wr_xing),
        .rd_data (rd_data)
    );

    l1lp_window_seq #(.NCH(NCH), .DEPTH(DEPTH), .WIN(WIN), .FDEPTH(FDEPTH)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .l1a        (l1a),
        .lat_cfg    (lat_cfg),
        .wr_xing    (wr_xing),
        .fifo_count (fifo_count),
        .rd_xing    (rd_xing),
        .rd_ch      (rd_ch),
        .push_v     (push_v),
        .push_tag   (push_tag),
        .push_ch    (push_ch),
        .push_sidx  (push_sidx),
        .busy       (busy),
        .overflow   (overflow)
    );

    assign push_e = '{tag: push_tag, ch: push_ch, sidx: push_sidx, smp: rd_data};

    l1lp_readout_fifo #(.WIDTH($bits(entry_t)), .FDEPTH(FDEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push_v),
        .push_data (push_e),
        .pop_req   (rd_en),
        .out_valid (out_valid),
        .out_data  (head_e),
        .full      (fifo_full),
        .count     (fifo_count)
    );

    assign out_tag    = head_e.tag;
    assign out_ch     = head_e.ch;
    assign out_sidx   = head_e.sidx;
    assign out_sample = head_e.smp;

endmodule

// File: rtl/l1_latency_pipe_chk.sv
module l1_latency_pipe_chk #(
    parameter int SW  = 3,
    parameter int WIN = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          l1a,
    input logic          busy,
    input logic          push_v,
    input logic          fifo_full,
    input logic          out_valid,
    input logic          overflow,
    input logic [SW-1:0] out_sidx
);

    a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    a_r10_busy_accept_drops: assert property (@(posedge clk) disable iff (rst)
        (l1a && busy) |=> overflow);

    a_r8_no_push_into_full: assert property (@(posedge clk) disable iff (rst)
        push_v |-> !fifo_full);

    a_r7_full_has_head: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> out_valid);

    a_r7_empty_needs_push: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !push_v) |=> !out_valid);

    a_r4_sidx_in_window: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(out_sidx) < WIN));

    a_r6_last_item_follows: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> push_v);

endmodule

bind l1_latency_pipe l1_latency_pipe_chk #(.SW(SW), .WIN(WIN)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .l1a       (l1a),
    .busy      (busy),
    .push_v    (push_v),
    .fifo_full (fifo_full),
    .out_valid (out_valid),
    .overflow  (overflow),
    .out_sidx  (out_sidx)
);

// File: tb/test_l1_latency_pipe.sv
module test_l1_latency_pipe;

    localparam int NCH    = 8;
    localparam int DEPTH  = 128;
    localparam int WIN    = 5;
    localparam int FDEPTH = 64;
    localparam int AW     = $clog2(DEPTH);
    localparam int CHW    = $clog2(NCH);
    localparam int SW     = $clog2(WIN);
    localparam int EVT    = NCH * WIN;

    typedef struct packed {
        logic [7:0]     tag;
        logic [CHW-1:0] ch;
        logic [SW-1:0]  s;
        logic [15:0]    d;
    } ent_t;

    logic           clk = 1'b0;
    logic           rst;
    logic [AW-1:0]  lat_cfg;
    logic           in_valid;
    logic [15:0]    in_sample;
    logic           l1a;
    logic           rd_en;
    logic           out_valid;
    logic [7:0]     out_tag;
    logic [CHW-1:0] out_ch;
    logic [SW-1:0]  out_sidx;
    logic [15:0]    out_sample;
    logic           fifo_full;
    logic           overflow;

    l1_latency_pipe #(.NCH(NCH), .DEPTH(DEPTH), .WIN(WIN), .FDEPTH(FDEPTH)) i_l1_latency_pipe (
        .clk, .rst, .lat_cfg, .in_valid, .in_sample, .l1a, .rd_en,
        .out_valid, .out_tag, .out_ch, .out_sidx, .out_sample, .fifo_full, .overflow
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;

    // reference model state
    ent_t        fifo_q[$];
    ent_t        pend_e[$];
    int          pend_due[$];
    logic [15:0] hist[int];
    int          xc, wch, tagc, busy_last, edge_k;
    bit          m_ovf;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        fifo_q.delete(); pend_e.delete(); pend_due.delete(); hist.delete();
        xc = 0; wch = 0; tagc = 0; busy_last = -1; m_ovf = 0;
    endtask

    // behaviour of the coming edge edge_k+1 for the inputs just driven
    task automatic model_step(input bit v, input logic [15:0] d, input bit a, input bit r, input int lat);
        int k;
        bit popnow;
        k = edge_k + 1;
        popnow = r && (fifo_q.size() > 0);
        if (a) begin
            if (k <= busy_last || (FDEPTH - fifo_q.size() - pend_e.size()) < EVT) begin
                m_ovf = 1;
            end else begin
                for (int c = 0; c < NCH; c++)
                    for (int s = 0; s < WIN; s++) begin
                        ent_t e;
                        e.tag = 8'(tagc);
                        e.ch  = CHW'(c);
                        e.s   = SW'(s);
                        e.d   = hist[(xc - lat + s) * NCH + c];
                        pend_e.push_back(e);
                        pend_due.push_back(k + 2 + c * WIN + s);
                    end
                busy_last = k + EVT;
            end
            tagc = (tagc + 1) % 256;
        end
        if (popnow) void'(fifo_q.pop_front());
        if (pend_e.size() > 0 && pend_due[0] == k) begin
            fifo_q.push_back(pend_e.pop_front());
            void'(pend_due.pop_front());
        end
        if (v) begin
            hist[xc * NCH + wch] = d;
            wch++;
            if (wch == NCH) begin wch = 0; xc++; end
        end
    endtask

    task automatic compare();
        bit mv;
        mv = fifo_q.size() > 0;
        chk(out_valid == mv, "R7 out_valid", out_valid, mv);
        if (out_valid && mv) begin
            chk(out_tag == fifo_q[0].tag, "R5 tag", out_tag, fifo_q[0].tag);
            chk(out_ch == fifo_q[0].ch && out_sidx == fifo_q[0].s, "R4 R6 order", {out_ch, out_sidx},
                {fifo_q[0].ch, fifo_q[0].s});
            chk(out_sample == fifo_q[0].d, "R2 R3 R11 R12 window sample", out_sample, fifo_q[0].d);
        end
        chk(fifo_full == (fifo_q.size() == FDEPTH), "R8 full", fifo_full, fifo_q.size() == FDEPTH);
        chk(overflow == m_ovf, "R9 R10 overflow", overflow, m_ovf);
    endtask

    task automatic cyc(input bit v, input logic [15:0] d, input bit a, input bit r);
        in_valid = v; in_sample = d; l1a = a; rd_en = r;
        model_step(v, d, a, r, int'(lat_cfg));
        @(posedge clk);
        edge_k++;
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset();
        rst = 1; in_valid = 0; in_sample = '0; l1a = 0; rd_en = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
        chk(out_valid == 0, "R1 empty after reset", out_valid, 0);
        chk(fifo_full == 0, "R1 full after reset", fifo_full, 0);
        chk(overflow == 0, "R1 overflow after reset", overflow, 0);
    endtask

    // mode 0: no reads, 1: always read, 2: read two cycles in three
    task automatic run_stream(input int n, input int mode, input int a1, input int a2);
        for (int i = 0; i < n; i++) begin
            bit r;
            r = (mode == 1) || (mode == 2 && (i % 3) != 0);
            cyc((i % 13) != 7, 16'($urandom), (i == a1) || (i == a2), r);
        end
    endtask

    initial begin
        #(150000 * 10);
        n_errors++; n_checks++;
        $display("FAIL R7 watchdog expired actual=%0h expected=%0h", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        edge_k = 0;
        lat_cfg = AW'(100);
        rst = 1;
        @(negedge clk);
        do_reset();
        // R3 with latency 100, then R10: accept while extraction runs
        run_stream(1100, 0, 1000, 1010);
        run_stream(100, 2, -1, -1);

        do_reset();
        // R9/R12: latency 112 after pointer wrap, second event finds no room
        lat_cfg = AW'(112);
        run_stream(1300, 0, 1200, 1250);
        run_stream(150, 1, -1, -1);

        do_reset();
        // R7/R11: minimum latency, overlapping push and pop, latency change
        lat_cfg = AW'(WIN);
        run_stream(1000, 2, 300, 600);
        run_stream(500, 2, 100, 350);
        lat_cfg = AW'(64);
        run_stream(600, 2, 300, -1);
        run_stream(200, 1, -1, -1);
        chk(out_valid == 0, "R7 drained at end", out_valid, 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule